// File: doc/BRIEF.md
# Strap-Configured Multiplexed GPIO Port

This block is a 16-pin general-purpose I/O port. Every pin is shared with one alternate signal from elsewhere in the chip. Pins 15..8 carry upper address lines 31..24. Pin 7 carries a transfer-in-progress strobe. Pins 6 and 5 carry two DMA request inputs. Pins 4..2 carry three transfer-modifier outputs, and pins 1..0 carry two transfer-type outputs. Three 32-bit registers sit in a 16-byte window of a register bus. A function-select register hands each pin either to the GPIO logic or to its alternate source. A direction register makes each GPIO pin an input or an output. A data register holds the output latch and reads back the synchronised pad levels.

The function-select register does not come out of reset at a fixed value. It takes a configuration strap on the first clock edge after reset is released. A low strap leaves every pin as GPIO; a high strap hands every pin to its alternate function. Software can then move pins one at a time. For example, pins 15..10 can become GPIO while pins 9..8 stay address lines.

Requests use a valid/ready handshake. `req_ready` is low during reset and during the strap-load cycle, so a request must hold `req_valid` and its fields steady until it sees ready. After that, ready stays high and every request is taken in one cycle. A read returns its data with `rsp_valid` exactly one cycle after acceptance. The response has no back-pressure, so the requester must accept it in that cycle. Alternate input functions take their level straight from `pad_in`, outside this block.

Top module: `gpio_mux_port`

## Requirements
- R1: Each bit of the function-select register (offset 0x4) controls only its own pin: 0 selects GPIO and 1 selects the alternate signal. Any mix is allowed, for example pins 15..10 as GPIO and pins 9..8 as alternate. The register changes only through an accepted write to it, or through the strap load.
- R2: For a pin in GPIO mode, `pad_oe` equals its direction bit (offset 0x8, where 1 means output) and `pad_out` equals its data-latch bit (offset 0xC). Both take effect in the cycle after the write is accepted.
- R3: For a pin in alternate mode, `pad_out` follows `alt_out` and `pad_oe` follows `alt_oe`. The direction and data-latch bits have no effect on that pin.
- R4: In the first clock after reset release, the function-select register loads all ones if `cfg_strap` is 1 and all zeros if it is 0. The direction register and the data latch reset to 0.
- R5: The registers sit at BASE+0x4 (function select), BASE+0x8 (direction) and BASE+0xC (data). Writes use `req_wdata[15:0]`, and read data bits 31..16 are always 0.
- R6: A read of the data register returns `pad_in` through a two-flop synchroniser. The read returns the new level only if it is accepted at the third or a later rising edge after the level changes. Reads accepted at the first or second edge after the change return the old level.
- R7: Writes to BASE+0x0 or to any address outside the 16-byte window change nothing. Reads of those addresses still respond, with data 0.
- R8: `req_ready` is 0 while reset is asserted and in the cycle after release, and 1 from then on. Each accepted read raises `rsp_valid` for exactly one cycle, one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_strap | input | 1 | Configuration strap, sampled at reset release |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 32 | Read data |
| alt_out | input | 16 | Alternate-function output values |
| alt_oe | input | 16 | Alternate-function output enables |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |

## Verification
The assertions rely on the requester keeping its request stable until it is accepted. They also rely on `cfg_strap` holding steady across reset release, since the strap check compares the loaded register with the strap value seen one cycle earlier. The bench meets both conditions. It drives all inputs only on falling edges, calls its bus tasks only when `req_ready` is high, and changes the strap only while reset is held. `pad_in` changes at a falling edge, and reads are placed a known number of rising edges later. This keeps the synchroniser's latency exact, not probabilistic.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned OFS_W = 4;

  localparam logic [OFS_W-1:0] OFS_SELECT = 4'h4;
  localparam logic [OFS_W-1:0] OFS_DIR    = 4'h8;
  localparam logic [OFS_W-1:0] OFS_DATA   = 4'hC;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_SELECT = 2'd1,
    SEL_DIR    = 2'd2,
    SEL_DATA   = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
    case (ofs)
      OFS_SELECT: decode_ofs = SEL_SELECT;
      OFS_DIR:    decode_ofs = SEL_DIR;
      OFS_DATA:   decode_ofs = SEL_DATA;
      default:    decode_ofs = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned N      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] pin_sync
);

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], pin_in[b]};
    end
    assign pin_sync[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] fsel,
  input  logic [N-1:0] dir,
  input  logic [N-1:0] dat,
  input  logic [N-1:0] alt_out,
  input  logic [N-1:0] alt_oe,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe
);

  for (genvar p = 0; p < N; p++) begin : g_pin
    always_comb begin
      if (fsel[p]) begin
        pad_out[p] = alt_out[p];
        pad_oe[p]  = alt_oe[p];
      end else begin
        pad_out[p] = dat[p];
        pad_oe[p]  = dir[p];
      end
    end
  end

endmodule

// File: rtl/gpio_bus_regs.sv
module gpio_bus_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned N    = 16,
  parameter logic [31:0] BASE = 32'h0000_0C00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_strap,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic         req_write,
  input  logic [31:0]  req_addr,
  input  logic [31:0]  req_wdata,
  output logic         rsp_valid,
  output logic [31:0]  rsp_rdata,
  input  logic [N-1:0] pin_sync,
  output logic [N-1:0] fsel_q,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] dat_q,
  output logic         armed_q
);

  logic     win_hit;
  reg_sel_e sel;
  logic     accept;
  logic     acc_wr;
  logic     acc_rd;
  logic [31:0] rd_mux;

  assign win_hit   = (req_addr[31:OFS_W] == BASE[31:OFS_W]);
  assign sel       = win_hit ? decode_ofs(req_addr[OFS_W-1:0]) : SEL_NONE;
  assign req_ready = armed_q;
  assign accept    = req_valid && armed_q;
  assign acc_wr    = accept && req_write;
  assign acc_rd    = accept && !req_write;

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_SELECT: rd_mux[N-1:0] = fsel_q;
      SEL_DIR:    rd_mux[N-1:0] = dir_q;
      SEL_DATA:   rd_mux[N-1:0] = pin_sync;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      fsel_q  <= '0;
      dir_q   <= '0;
      dat_q   <= '0;
    end else if (!armed_q) begin
      armed_q <= 1'b1;
      fsel_q  <= {N{cfg_strap}};
    end else if (acc_wr) begin
      case (sel)
        SEL_SELECT: fsel_q <= req_wdata[N-1:0];
        SEL_DIR:    dir_q  <= req_wdata[N-1:0];
        SEL_DATA:   dat_q  <= req_wdata[N-1:0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc_rd;
      if (acc_rd) rsp_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
  parameter int unsigned N    = 16,
  parameter logic [31:0] BASE = 32'h0000_0C00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_strap,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic         req_write,
  input  logic [31:0]  req_addr,
  input  logic [31:0]  req_wdata,
  output logic         rsp_valid,
  output logic [31:0]  rsp_rdata,
  input  logic [N-1:0] alt_out,
  input  logic [N-1:0] alt_oe,
  input  logic [N-1:0] pad_in,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [N-1:0] pin_sync;
  logic [N-1:0] fsel_q;
  logic [N-1:0] dir_q;
  logic [N-1:0] dat_q;
  logic         armed_q;

  gpio_in_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pad_in),
    .pin_sync (pin_sync)
  );

  gpio_bus_regs #(.N(N), .BASE(BASE)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_strap (cfg_strap),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .pin_sync  (pin_sync),
    .fsel_q    (fsel_q),
    .dir_q     (dir_q),
    .dat_q     (dat_q),
    .armed_q   (armed_q)
  );

  gpio_pin_mux #(.N(N)) u_mux (
    .fsel    (fsel_q),
    .dir     (dir_q),
    .dat     (dat_q),
    .alt_out (alt_out),
    .alt_oe  (alt_oe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
  parameter int unsigned N    = 16,
  parameter logic [31:0] BASE = 32'h0000_0C00
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_strap,
  input logic         req_valid,
  input logic         req_ready,
  input logic         req_write,
  input logic [31:0]  req_addr,
  input logic [31:0]  req_wdata,
  input logic         rsp_valid,
  input logic [31:0]  rsp_rdata,
  input logic [N-1:0] pad_oe,
  input logic [N-1:0] fsel_q,
  input logic         armed_q
);

  logic rd_acc;
  logic wr_acc;
  logic dir_wr;
  assign rd_acc = req_valid && req_ready && !req_write;
  assign wr_acc = req_valid && req_ready && req_write;
  assign dir_wr = wr_acc && (req_addr == BASE + 32'h8);

  // R8: an accepted read yields a response on the next cycle
  assert_read_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);

  // R8: no response without an accepted read one cycle earlier
  assert_resp_has_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_acc));

  // R5: unused upper read bits are zero
  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_rdata >> N) == 32'd0));

  // R4: the strap is loaded into every select bit when the port arms
  assert_strap_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> (fsel_q == {N{$past(cfg_strap)}}));

  // R1: select register only moves on an accepted write
  assert_select_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !wr_acc) |=> $stable(fsel_q));

  // R2: a direction write shows on GPIO pins' output enables next cycle
  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> (((pad_oe ^ $past(req_wdata[N-1:0])) & ~fsel_q) == '0));

endmodule

bind gpio_mux_port gpio_mux_port_chk #(.N(N), .BASE(BASE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_strap (cfg_strap),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .pad_oe    (pad_oe),
  .fsel_q    (fsel_q),
  .armed_q   (armed_q)
);

// File: tb/sim_gpio_mux_port.sv
module sim_gpio_mux_port;

  localparam int unsigned N    = 16;
  localparam logic [31:0] BASE = 32'h0000_0C00;
  localparam logic [31:0] A_SEL = BASE + 32'h4;
  localparam logic [31:0] A_DIR = BASE + 32'h8;
  localparam logic [31:0] A_DAT = BASE + 32'hC;

  typedef struct packed {
    logic [15:0] fsel;
    logic [15:0] dir;
    logic [15:0] dat;
    logic [15:0] aout;
    logic [15:0] aoe;
    logic [15:0] xout;
    logic [15:0] xoe;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 16'hFFFF, 16'hA5A5, 16'h0000, 16'h0000, 16'hA5A5, 16'hFFFF},
    '{16'hFFFF, 16'hFFFF, 16'hA5A5, 16'h1234, 16'h00F0, 16'h1234, 16'h00F0},
    '{16'h03FF, 16'hFC00, 16'h5400, 16'hFFFF, 16'h03FF, 16'h57FF, 16'hFFFF},
    '{16'h00FF, 16'h0F0F, 16'h3C3C, 16'h0F0F, 16'hAAAA, 16'h3C0F, 16'h0FAA}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_strap = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_write = 1'b0;
  logic [31:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;
  logic [N-1:0] alt_out = '0;
  logic [N-1:0] alt_oe = '0;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out;
  logic [N-1:0] pad_oe;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  gpio_mux_port #(.N(N), .BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_strap(cfg_strap),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .alt_out(alt_out), .alt_oe(alt_oe), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // All bus tasks start and end at a falling edge.
  task automatic bus_wr(input logic [31:0] addr, input logic [31:0] data);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = addr; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [31:0] addr, output logic [31:0] data, output logic vld);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    data = rsp_rdata;
    vld  = rsp_valid;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_strap = strap;
    repeat (3) @(negedge clk);
    check("R8 ready low in reset", {31'd0, req_ready}, 32'd0);
    rst_n = 1'b1;
    #1;
    check("R8 ready low before first edge", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    check("R8 ready high after strap load", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    logic [31:0] rd;
    logic        v;

    // Reset with strap low: everything GPIO, inputs
    alt_oe  = 16'hFFFF;
    alt_out = 16'hFFFF;
    do_reset(1'b0);
    bus_rd(A_SEL, rd, v);
    check("R4 select after low strap", rd, 32'h0000_0000);
    check("R8 read response valid", {31'd0, v}, 32'd1);
    @(negedge clk);
    check("R8 response lasts one cycle", {31'd0, rsp_valid}, 32'd0);
    bus_rd(A_DIR, rd, v);
    check("R4 direction reset", rd, 32'h0);
    check("R4 pad_oe all inputs", {16'd0, pad_oe}, 32'h0);
    check("R4 data latch reset", {16'd0, pad_out}, 32'h0);

    // Table walk: R1 R2 R3
    for (int i = 0; i < NV; i++) begin
      alt_out = VECS[i].aout;
      alt_oe  = VECS[i].aoe;
      bus_wr(A_DIR, {16'd0, VECS[i].dir});
      bus_wr(A_DAT, {16'd0, VECS[i].dat});
      bus_wr(A_SEL, {16'd0, VECS[i].fsel});
      check($sformatf("R1/R2/R3 vector %0d pad_out", i), {16'd0, pad_out}, {16'd0, VECS[i].xout});
      check($sformatf("R1/R2/R3 vector %0d pad_oe", i), {16'd0, pad_oe}, {16'd0, VECS[i].xoe});
    end

    // R3: changing direction/data on alternate pins has no effect (select = 00FF)
    bus_wr(A_DIR, 32'h0000_0F00);
    bus_wr(A_DAT, 32'h0000_FF00);
    check("R3 alt pins ignore dir/data pad_out", {16'd0, pad_out}, 32'h0000_FF0F);
    check("R3 alt pins ignore dir/data pad_oe", {16'd0, pad_oe}, 32'h0000_0FAA);

    // R5: upper bits
    bus_wr(A_DIR, 32'hFFFF_FFFF);
    bus_rd(A_DIR, rd, v);
    check("R5 direction readback upper zero", rd, 32'h0000_FFFF);
    bus_rd(A_SEL, rd, v);
    check("R5 select readback", rd, 32'h0000_00FF);

    // R7: unmapped accesses
    bus_wr(BASE, 32'h0000_0000);
    bus_wr(32'h0000_2004, 32'h0000_FFFF);
    bus_rd(A_SEL, rd, v);
    check("R7 unmapped writes ignored", rd, 32'h0000_00FF);
    bus_rd(BASE, rd, v);
    check("R7 unmapped read data", rd, 32'h0);
    check("R7 unmapped read responds", {31'd0, v}, 32'd1);

    // R6: synchroniser latency
    pad_in = 16'hBEEF;
    repeat (2) @(negedge clk);
    bus_rd(A_DAT, rd, v);
    check("R6 data read after settle", rd, 32'h0000_BEEF);
    pad_in = 16'h1234;
    bus_rd(A_DAT, rd, v);
    check("R6 read at first edge keeps old", rd, 32'h0000_BEEF);
    bus_rd(A_DAT, rd, v);
    check("R6 read at second edge keeps old", rd, 32'h0000_BEEF);
    bus_rd(A_DAT, rd, v);
    check("R6 read at third edge sees new", rd, 32'h0000_1234);

    // Reset with strap high: everything alternate
    alt_out = 16'h00FF;
    alt_oe  = 16'h5A5A;
    do_reset(1'b1);
    bus_rd(A_SEL, rd, v);
    check("R4 select after high strap", rd, 32'h0000_FFFF);
    check("R3 high strap pad_out from alt", {16'd0, pad_out}, 32'h0000_00FF);
    check("R3 high strap pad_oe from alt", {16'd0, pad_oe}, 32'h0000_5A5A);
    bus_rd(A_DIR, rd, v);
    check("R4 direction reset with high strap", rd, 32'h0);

    // R1: pins 15..10 to GPIO output, 9..8 stay alternate
    bus_wr(A_DIR, 32'h0000_FC00);
    bus_wr(A_SEL, 32'h0000_03FF);
    check("R1 upper six GPIO, 9..8 alternate oe", {16'd0, pad_oe}, 32'h0000_FE5A);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule